// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable, small-depth model of a synchronous static RAM whose bus can switch between reads and writes with no idle cycle. On each enabled rising edge the block samples an address and a command: read, write, deselect, or burst advance. The data transfer for that command takes place in the following clock cycle. Read data leaves the array combinationally at the registered address, so there is no output register stage. Write data is captured at the edge that closes the data cycle. The data bus is modelled as a separate input, output and output-enable.

An internal 2-bit burst counter produces four words from one loaded address. A static order input selects linear or interleaved sequencing. An active-low clock enable freezes the whole block. Three chip selects gate new operations. Per-lane write enables mask 9-bit lanes. An asynchronous output enable floats the outputs at once. A sleep input blocks new work and keeps the stored contents.

Top module: `zbt_sram`

## Requirements
- R1: A read command sampled at edge k drives its word on `dout` with `dout_en` high during the cycle after edge k. A write command sampled at edge k writes the `din` presented during that following cycle, at edge k+1.
- R2: Read data is flow-through: during a read data cycle, `dout` equals the array word at the registered address. This includes a word written at the edge that began the cycle, so write-then-read and read-then-write need no idle cycle.
- R3: While `clk_en_n` is 1, every command input is ignored, no write occurs, and all internal state holds. A pending read keeps driving the same word.
- R4: A new operation starts only on a load cycle (`adv`=0) with `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Any other chip-select combination on a load cycle is a deselect.
- R5: `dout_en` is low in the cycle after a deselect or after a write command.
- R6: An advance cycle (`adv`=1) repeats the last loaded operation type at the next burst address and ignores `rw` and the chip selects. After a deselect, an advance is a no-op and `dout_en` stays low.
- R7: Burst word n (n=1,2,3, then wrapping to 0) uses low address bits equal to start+n mod 4 when `burst_ilv`=0, and start XOR n when `burst_ilv`=1. Address bits above bit 1 never change within a burst.
- R8: `byte_we_n[0]` (active low) enables bits 8:0 and `byte_we_n[1]` enables bits 17:9. The enables are sampled with each load or advance, and only the enabled lanes are written.
- R9: `oe_n`=1 forces `dout_en` low in the same cycle, regardless of pipeline state.
- R10: While `sleep` is 1, no new operation starts and `dout_en` is low. Stored data is kept, and a read loaded on the first edge after `sleep` falls returns it normally.
- R11: After reset `dout_en` is 0, and a read of any lane never written since reset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Clock enable, active low; 1 suspends the block |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| adv | input | 1 | 0 = load new command, 1 = advance burst |
| rw | input | 1 | 1 = read, 0 = write (load cycles only) |
| byte_we_n | input | LANES | Per-lane write enables, active low |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep: blocks new operations, floats outputs |
| addr | input | AW | Word address |
| din | input | LANES*LANE_W | Write data for the current data cycle |
| dout | output | LANES*LANE_W | Read data, flow-through from the array |
| dout_en | output | 1 | Output-drive enable for the data bus |

## Verification
On every cycle, the assertions check that the bus is released after a deselect or a write command, that `oe_n` and `sleep` keep `dout_en` low, that a suspended cycle changes no state, and that a burst stays inside its 4-word group. Other behaviour can only be shown by the bench's scenarios, which compare every data cycle against a reference scoreboard. These scenarios cover the word values returned, the linear and interleaved orders with wrap-around, the partial lane writes, the back-to-back turnaround, a pending read that survives a suspension, and data kept across sleep.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;
  typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_READ = 2'd1, OP_WRITE = 2'd2} op_e;

  // low address bits of burst word n from the loaded start
  function automatic logic [1:0] burst_low(input logic [1:0] start, input logic [1:0] n,
                                           input logic ilv);
    return ilv ? (start ^ n) : (start + n);
  endfunction
endpackage

// File: rtl/zbt_ctrl.sv
`timescale 1ns/1ps
module zbt_ctrl
  import zbt_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             sleep,
  input  logic             load,
  input  logic             sel,
  input  logic             rw,
  input  logic [LANES-1:0] be_n,
  input  logic             ilv,
  input  logic [AW-1:0]    addr,
  output op_e              dp_op,
  output logic [AW-1:0]    dp_addr,
  output logic [LANES-1:0] dp_be_n
);
  op_e           last_op;
  logic [AW-1:0] base;
  logic [1:0]    cnt;
  logic [1:0]    cnt_nx;
  logic [AW-1:0] burst_addr;

  assign cnt_nx     = cnt + 2'd1;
  assign burst_addr = {base[AW-1:2], burst_low(base[1:0], cnt_nx, ilv)};

  always_ff @(posedge clk) begin
    if (rst) begin
      dp_op   <= OP_IDLE;
      last_op <= OP_IDLE;
      dp_addr <= '0;
      dp_be_n <= '1;
      base    <= '0;
      cnt     <= '0;
    end else if (ce) begin
      if (sleep) begin
        dp_op   <= OP_IDLE;
        last_op <= OP_IDLE;
      end else if (load) begin
        if (sel) begin
          dp_op   <= rw ? OP_READ : OP_WRITE;
          last_op <= rw ? OP_READ : OP_WRITE;
          dp_addr <= addr;
          dp_be_n <= be_n;
          base    <= addr;
          cnt     <= '0;
        end else begin
          dp_op   <= OP_IDLE;
          last_op <= OP_IDLE;
        end
      end else begin
        dp_op <= last_op;
        if (last_op != OP_IDLE) begin
          cnt     <= cnt_nx;
          dp_addr <= burst_addr;
          dp_be_n <= be_n;
        end
      end
    end
  end

  // R3: a suspended cycle leaves the data-phase state untouched
  p_suspend_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(dp_op) && $stable(dp_addr) && $stable(dp_be_n)));

  // R7: an advance never leaves the 4-word group
  p_burst_group_r7: assert property (@(posedge clk) disable iff (rst)
    (ce && !sleep && !load && dp_op != OP_IDLE)
      |=> (dp_addr[AW-1:2] == $past(dp_addr[AW-1:2])));

  // R6: an advance after a deselect stays idle
  p_adv_noop_r6: assert property (@(posedge clk) disable iff (rst)
    (ce && !sleep && !load && last_op == OP_IDLE) |=> (dp_op == OP_IDLE));
endmodule

// File: rtl/zbt_lane.sv
`timescale 1ns/1ps
module zbt_lane #(
  parameter int AW = 8,
  parameter int W  = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] written;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     written       <= '0;
    else if (we) written[addr] <= 1'b1;
  end

  assign rdata = written[addr] ? mem[addr] : '0;
endmodule

// File: rtl/zbt_array.sv
`timescale 1ns/1ps
module zbt_array #(
  parameter int AW     = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [LANES-1:0]        be_n,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    zbt_lane #(.AW(AW), .W(LANE_W)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .we    (we && !be_n[g]),
      .addr  (addr),
      .wdata (wdata[g*LANE_W +: LANE_W]),
      .rdata (rdata[g*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/zbt_sram.sv
`timescale 1ns/1ps
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int AW     = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clk_en_n,
  input  logic                    cs1_n,
  input  logic                    cs2,
  input  logic                    cs3_n,
  input  logic                    adv,
  input  logic                    rw,
  input  logic [LANES-1:0]        byte_we_n,
  input  logic                    burst_ilv,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);
  op_e              dp_op;
  logic [AW-1:0]    dp_addr;
  logic [LANES-1:0] dp_be_n;
  logic             sel_all;
  logic             ce;

  assign ce      = !clk_en_n;
  assign sel_all = !cs1_n && cs2 && !cs3_n;

  zbt_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .ce      (ce),
    .sleep   (sleep),
    .load    (!adv),
    .sel     (sel_all),
    .rw      (rw),
    .be_n    (byte_we_n),
    .ilv     (burst_ilv),
    .addr    (addr),
    .dp_op   (dp_op),
    .dp_addr (dp_addr),
    .dp_be_n (dp_be_n)
  );

  zbt_array #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk   (clk),
    .rst   (rst),
    .we    (ce && dp_op == OP_WRITE),
    .be_n  (dp_be_n),
    .addr  (dp_addr),
    .wdata (din),
    .rdata (dout)
  );

  assign dout_en = !oe_n && !sleep && (dp_op == OP_READ);

  // R5: bus released after a deselect load
  p_release_desel_r5: assert property (@(posedge clk) disable iff (rst)
    (ce && !sleep && !adv && !sel_all) |=> !dout_en);

  // R5: bus released after a write load
  p_release_write_r5: assert property (@(posedge clk) disable iff (rst)
    (ce && !sleep && !adv && sel_all && !rw) |=> !dout_en);

  // R9: output enable floats the bus in the same cycle
  p_oe_float_r9: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dout_en);

  // R10: sleep keeps the bus floating
  p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !dout_en);
endmodule

// File: tb/zbt_sram_tb.sv
`timescale 1ns/1ps
module zbt_sram_tb;
  localparam int  AW    = 8;
  localparam int  DW    = 18;
  localparam real CLK_P = 5.0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_en_n = 1'b0, cs1_n = 1'b1, cs2 = 1'b1, cs3_n = 1'b0;
  logic          adv = 1'b1, rw = 1'b1, burst_ilv = 1'b0, oe_n = 1'b0, sleep = 1'b0;
  logic [1:0]    byte_we_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en;

  always #(CLK_P/2) clk = ~clk;

  zbt_sram u_dut (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .adv(adv), .rw(rw), .byte_we_n(byte_we_n), .burst_ilv(burst_ilv), .oe_n(oe_n),
    .sleep(sleep), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  typedef struct {
    logic          en;
    logic [DW-1:0] d;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;

  // globals used by the driver
  logic       g_cen_n = 1'b0, g_ilv = 1'b0, g_oe_n = 1'b0, g_slp = 1'b0;
  logic [2:0] g_cs = 3'b010;  // {cs1_n, cs2, cs3_n}: selected

  // reference state built from the requirements
  logic [DW-1:0] refm [1 << AW];
  logic          pv = 1'b0, pw = 1'b0, live = 1'b0;
  logic [AW-1:0] pa = '0, base = '0;
  logic [1:0]    pb = 2'b11, cnt = 2'b00;

  task automatic step(input logic adv_i, input logic rw_i, input logic [AW-1:0] a,
                      input logic [1:0] be, input logic [DW-1:0] d, input logic desel,
                      input string tag);
    exp_t e;
    logic sel;
    @(posedge clk); #1;
    clk_en_n = g_cen_n; cs1_n = desel ? 1'b1 : g_cs[2]; cs2 = g_cs[1]; cs3_n = g_cs[0];
    adv = adv_i; rw = rw_i; addr = a; byte_we_n = be; burst_ilv = g_ilv;
    oe_n = g_oe_n; sleep = g_slp; din = d;
    e.en = pv && !pw && !g_oe_n && !g_slp;
    e.d = refm[pa];
    e.tag = tag;
    q.push_back(e);
    sel = !cs1_n && cs2 && !cs3_n;
    if (!g_cen_n) begin
      if (pv && pw) begin
        if (!pb[0]) refm[pa][8:0]  = d[8:0];
        if (!pb[1]) refm[pa][17:9] = d[17:9];
      end
      if (g_slp) begin
        pv = 1'b0; live = 1'b0;
      end else if (!adv_i) begin
        if (sel) begin
          pv = 1'b1; pw = !rw_i; pa = a; base = a; cnt = 2'b00; pb = be; live = 1'b1;
        end else begin
          pv = 1'b0; live = 1'b0;
        end
      end else if (live) begin
        cnt = cnt + 2'd1;
        pa = {base[AW-1:2], g_ilv ? (base[1:0] ^ cnt) : (base[1:0] + cnt)};
        pv = 1'b1; pb = be;
      end else begin
        pv = 1'b0;
      end
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    step(1'b0, 1'b1, a, 2'b11, d, 1'b0, tag);
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic [1:0] be, input logic [DW-1:0] d,
                    input string tag);
    step(1'b0, 1'b0, a, be, d, 1'b0, tag);
  endtask
  task automatic ad(input logic [1:0] be, input logic [DW-1:0] d, input string tag);
    step(1'b1, 1'b1, '0, be, d, 1'b0, tag);
  endtask
  task automatic nop(input logic [DW-1:0] d, input string tag);
    step(1'b0, 1'b1, '0, 2'b11, d, 1'b1, tag);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (dout_en !== e.en) begin
        errors++;
        $display("FAIL %s dout_en actual=%b expected=%b", e.tag, dout_en, e.en);
      end else if (e.en && dout !== e.d) begin
        errors++;
        $display("FAIL %s dout actual=%h expected=%h", e.tag, dout, e.d);
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) refm[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (dout_en !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset dout_en actual=%b expected=0", dout_en);
    end
    @(posedge clk); #1 rst = 1'b0;

    // R11 unwritten read, R1 write then read timing, R2 flow-through
    rd(8'h05, '0, "R11");
    wr(8'h0A, 2'b00, '0, "R11");
    rd(8'h0A, 18'h2A5A5, "R1");
    nop('0, "R2");

    // R7 linear write burst from 0x21, R6 advance ignores rw and selects
    g_ilv = 1'b0;
    wr(8'h21, 2'b00, '0, "R5");
    ad(2'b00, 18'h11111, "R5");
    ad(2'b00, 18'h12222, "R7");
    g_cs = 3'b101;
    ad(2'b00, 18'h13333, "R6");
    g_cs = 3'b010;
    nop(18'h14444, "R6");

    // R7 interleaved read burst from 0x22 with wrap
    g_ilv = 1'b1;
    rd(8'h22, '0, "R7");
    for (int k = 0; k < 5; k++) ad(2'b11, '0, "R7");

    // R8 byte lanes
    wr(8'h0A, 2'b10, '0, "R7");
    rd(8'h0A, 18'h3FFFF, "R8");
    wr(8'h28, 2'b01, '0, "R8");
    rd(8'h28, 18'h3FFFF, "R8");
    nop('0, "R8");

    // R4 chip selects, R6 advance after deselect
    g_cs = 3'b000;
    rd(8'h0A, '0, "R4");
    ad(2'b11, '0, "R6");
    ad(2'b11, '0, "R6");
    g_cs = 3'b011;
    rd(8'h0A, '0, "R4");
    g_cs = 3'b010;
    nop('0, "R4");

    // R2 read->write->read turnaround
    rd(8'h0A, '0, "R2");
    wr(8'h0B, 2'b00, '0, "R2");
    rd(8'h0B, 18'h0ABCD, "R5");
    nop('0, "R2");

    // R3 clock enable suspends mid-burst
    g_ilv = 1'b0;
    rd(8'h20, '0, "R3");
    ad(2'b11, '0, "R3");
    g_cen_n = 1'b1;
    rd(8'h05, '0, "R3");
    wr(8'h20, 2'b00, 18'h3FFFF, "R3");
    g_cen_n = 1'b0;
    ad(2'b11, '0, "R3");
    nop('0, "R3");

    // R9 output enable
    rd(8'h0A, '0, "R9");
    g_oe_n = 1'b1;
    nop('0, "R9");
    g_oe_n = 1'b0;

    // R10 sleep
    rd(8'h0A, '0, "R10");
    g_slp = 1'b1;
    wr(8'h0C, 2'b00, '0, "R10");
    rd(8'h0C, 18'h3FFFF, "R10");
    g_slp = 1'b0;
    rd(8'h0A, '0, "R10");
    nop('0, "R10");
    nop('0, "R10");

    @(posedge clk);
    @(negedge clk); #1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule